// File: doc/BRIEF.md
# SPI Serial Clock Prescaler

This block derives the serial clock of an SPI master from the main clock. Two counters do the division in series. The first is a power-of-two stage that emits one tick every 2, 4, 8 or 16 main-clock cycles, chosen by a 2-bit scale field. The second counts those ticks and flips the serial clock once every (rate + 1) ticks, where the rate is a 6-bit field. One full serial period therefore lasts 2 * (rate + 1) * (2 << scale) main cycles.

Next to the clock level, the block issues a one-cycle strobe for each leading edge and each trailing edge. The shift engine uses these strobes to launch and capture data. The scale, rate and polarity fields are taken in only while the block is disabled. After the enable input rises, a ready flag comes up after a fixed settling count, and only then does a run request start the clock. Whenever the block is disabled, not ready, or has no run request, both counters clear and the clock rests at the polarity level.

Top module: `spi_clk_prescaler`

## Requirements
- R1: The serial clock changes level every H = (rate + 1) * (2 << scale) main-clock cycles, where rate is `brg_i` (legal 4..63) and scale is `div_i` (0..3). A full period is 2*H.
- R2: After `run_i` is first seen high at a clock edge while ready, the first level change appears on sample H, counting that edge as 1. Each further change follows H samples later.
- R3: A rate value below 4 is handled as 4, so the half period is never shorter than that of rate 4.
- R4: The fastest setting (scale 0, rate 4) gives a period of 20 main cycles. The slowest (scale 3, rate 63) gives 2048 main cycles.
- R5: While `en_i` is low, while `run_i` is low, or while `ready_o` is low, `sclk_o` equals the latched polarity. While `en_i` is low, `sclk_o` follows `cpol_i` one cycle later. Every new run restarts both counters from zero.
- R6: `div_i`, `brg_i` and `cpol_i` are captured only while `en_i` is low. Changing them while `en_i` is high has no effect on `sclk_o` or on the strobes.
- R7: `ready_o` is low while `en_i` is low. It rises on the READY_CYC-th cycle (default 4) that `en_i` is seen high. A run request held during that time produces no level change before then.
- R8: `lead_o` is high for exactly the one cycle in which `sclk_o` first shows the non-idle level (not equal to the polarity). `trail_o` is high for the one cycle in which `sclk_o` first returns to the polarity level. The two strobes are never high together.
- R9: If `run_i` is low at the edge where a level change would fall, the stop wins: no strobe, `sclk_o` at idle. The next run starts a full H count again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Device enable; the fields are latched while it is low |
| run_i | input | 1 | Run request from the shift engine |
| cpol_i | input | 1 | Clock polarity, which is the idle level of the serial clock |
| div_i | input | 2 | Power-of-two scale select (divide by 2 << div_i) |
| brg_i | input | 6 | Half-period rate count, minus one |
| sclk_o | output | 1 | Serial clock level |
| lead_o | output | 1 | One-cycle strobe on each move away from the idle level |
| trail_o | output | 1 | One-cycle strobe on each return to the idle level |
| ready_o | output | 1 | Enabled and settled |

## Verification
Two functions can claim the same cycle: a counted level change that is due, and the shift engine dropping its run request. The bench provokes this by holding run for exactly H-1 samples and releasing it right before the edge that would carry the change. It then expects the idle level with both strobes low on that edge, and a full H count on the next run. A second overlap is a field rewrite during a live run, done between edges in mid-phase. It is judged by checking that the strobe timing and polarity keep following the values captured before enable.

// File: rtl/scp_pkg.sv
package scp_pkg;
  localparam int DIV_W = 2;
  localparam int BRG_W = 6;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic [BRG_W-1:0] brg;
    logic             cpol;
  } scp_cfg_t;
endpackage

// File: rtl/scp_cfg_shadow.sv
module scp_cfg_shadow
  import scp_pkg::*;
#(
  parameter int READY_CYC = 4,
  parameter int BRG_MIN   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [BRG_W-1:0] brg_i,
  input  logic             cpol_i,
  output scp_cfg_t         cfg_o,
  output logic             ready_o
);
  localparam logic [BRG_W-1:0] BRG_FLOOR = BRG_W'(BRG_MIN);

  scp_cfg_t cfg_q;
  logic     rdy_q;

  // fields pass only while disabled; rate floored
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q.div  <= '0;
      cfg_q.brg  <= BRG_FLOOR;
      cfg_q.cpol <= 1'b0;
    end else if (!en_i) begin
      cfg_q.div  <= div_i;
      cfg_q.brg  <= (brg_i < BRG_FLOOR) ? BRG_FLOOR : brg_i;
      cfg_q.cpol <= cpol_i;
    end
  end

  generate
    if (READY_CYC <= 1) begin : g_rdy_direct
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) rdy_q <= 1'b0;
        else         rdy_q <= en_i;
      end
    end else begin : g_rdy_count
      localparam int RW = $clog2(READY_CYC);
      logic [RW-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          cnt_q <= '0;
          rdy_q <= 1'b0;
        end else if (!en_i) begin
          cnt_q <= '0;
          rdy_q <= 1'b0;
        end else if (!rdy_q) begin
          if (cnt_q == RW'(READY_CYC - 1)) rdy_q <= 1'b1;
          else                             cnt_q <= cnt_q + RW'(1);
        end
      end
    end
  endgenerate

  assign cfg_o   = cfg_q;
  assign ready_o = rdy_q;
endmodule

// File: rtl/scp_pow2_stage.sv
module scp_pow2_stage
  import scp_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam int CW = (2 ** DIV_W) + 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;

  assign lim    = (CW'(2) << div_i) - CW'(1);
  assign tick_o = !clr_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/scp_half_stage.sv
module scp_half_stage
  import scp_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [BRG_W-1:0] brg_i,
  output logic             toggle_o
);
  logic [BRG_W-1:0] cnt_q;

  assign toggle_o = tick_i && (cnt_q == brg_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clr_i)    cnt_q <= '0;
    else if (toggle_o) cnt_q <= '0;
    else if (tick_i)   cnt_q <= cnt_q + BRG_W'(1);
  end
endmodule

// File: rtl/scp_sclk_out.sv
module scp_sclk_out (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic toggle_i,
  input  logic cpol_i,
  output logic sclk_o,
  output logic lead_o,
  output logic trail_o
);
  logic phase_q, lead_q, trail_q;

  // strobes registered with the phase so they share its cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end else if (clr_i) begin
      phase_q <= 1'b0;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end else begin
      lead_q  <= toggle_i && !phase_q;
      trail_q <= toggle_i && phase_q;
      if (toggle_i) phase_q <= !phase_q;
    end
  end

  assign sclk_o  = cpol_i ^ phase_q;
  assign lead_o  = lead_q;
  assign trail_o = trail_q;
endmodule

// File: rtl/spi_clk_prescaler.sv
module spi_clk_prescaler
  import scp_pkg::*;
#(
  parameter int READY_CYC = 4,
  parameter int BRG_MIN   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             run_i,
  input  logic             cpol_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [BRG_W-1:0] brg_i,
  output logic             sclk_o,
  output logic             lead_o,
  output logic             trail_o,
  output logic             ready_o
);
  scp_cfg_t cfg;
  logic     rdy, clr, tick, toggle;

  scp_cfg_shadow #(.READY_CYC(READY_CYC), .BRG_MIN(BRG_MIN)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .div_i  (div_i),
    .brg_i  (brg_i),
    .cpol_i (cpol_i),
    .cfg_o  (cfg),
    .ready_o(rdy)
  );

  assign clr = !(en_i && run_i && rdy);

  scp_pow2_stage u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .div_i (cfg.div),
    .tick_o(tick)
  );

  scp_half_stage u_half (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .tick_i  (tick),
    .brg_i   (cfg.brg),
    .toggle_o(toggle)
  );

  scp_sclk_out u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .toggle_i(toggle),
    .cpol_i  (cfg.cpol),
    .sclk_o  (sclk_o),
    .lead_o  (lead_o),
    .trail_o (trail_o)
  );

  assign ready_o = rdy;
endmodule

// File: rtl/spi_clk_prescaler_chk.sv
module spi_clk_prescaler_chk #(
  parameter int BRG_MIN = 4
) (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic run_i,
  input logic cpol_i,
  input logic sclk_o,
  input logic lead_o,
  input logic trail_o,
  input logic ready_o
);
  localparam int MIN_HALF = (BRG_MIN + 1) * 2;
  localparam int GW = 12;

  logic [GW-1:0] gap_q;
  logic          seen_q;
  logic          strobe;

  assign strobe = lead_o || trail_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (!(en_i && run_i)) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (strobe) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else if (gap_q != '1) begin
      gap_q  <= gap_q + GW'(1);
    end
  end

  a_r5_idle_follows_cpol: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (sclk_o == $past(cpol_i)));

  a_r8_strobe_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lead_o && trail_o));

  a_r8_lead_moves: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lead_o |-> (sclk_o != $past(sclk_o)));

  a_r8_trail_moves: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trail_o |-> (sclk_o != $past(sclk_o)));

  a_r7_ready_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> $past(en_i));

  a_r7_lead_needs_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe |-> ($past(ready_o) && $past(run_i)));

  // R3 / R4: no half period shorter than the floored rate at scale 0
  a_r3_min_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe && seen_q) |-> (gap_q >= GW'(MIN_HALF - 1)));
endmodule

bind spi_clk_prescaler spi_clk_prescaler_chk #(.BRG_MIN(BRG_MIN)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .en_i   (en_i),
  .run_i  (run_i),
  .cpol_i (cpol_i),
  .sclk_o (sclk_o),
  .lead_o (lead_o),
  .trail_o(trail_o),
  .ready_o(ready_o)
);

// File: tb/sim_spi_clk_prescaler.sv
`timescale 1ns/1ps
module sim_spi_clk_prescaler;
  localparam int READY_CYC = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0, run = 1'b0, cpol = 1'b0;
  logic [1:0] div = '0;
  logic [5:0] brg = 6'd4;
  logic       sclk, lead, trail, rdy;
  int         n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  spi_clk_prescaler #(.READY_CYC(READY_CYC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .run_i(run), .cpol_i(cpol),
    .div_i(div), .brg_i(brg), .sclk_o(sclk), .lead_o(lead),
    .trail_o(trail), .ready_o(rdy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int half_len(input int d, input int b);
    int be = (b < 4) ? 4 : b;
    return (be + 1) * (2 << d);
  endfunction

  function automatic int exp_bits(input int n, input int h, input bit cp);
    int k = n / h;
    bit s = cp ^ k[0];
    bit l = (n % h == 0) && k[0];
    bit t = (n % h == 0) && !k[0];
    return {29'd0, s, l, t};
  endfunction

  task automatic configure(input int d, input int b, input bit cp, input bit pre_run);
    @(negedge clk);
    en = 1'b0; run = 1'b0;
    div = 2'(d); brg = 6'(b); cpol = cp;
    @(posedge clk); #1;
    chk(rdy == 1'b0, "R7", int'(rdy), 0);
    chk(sclk == cp, "R5", int'(sclk), int'(cp));
    @(negedge clk);
    en = 1'b1; run = pre_run;
    for (int k = 1; k <= READY_CYC; k++) begin
      @(posedge clk); #1;
      if (k == READY_CYC - 1) chk(rdy == 1'b0, "R7", int'(rdy), 0);
      if (k == READY_CYC)     chk(rdy == 1'b1, "R7", int'(rdy), 1);
      if (pre_run) chk(sclk == cp && !lead, "R7", int'({sclk, lead}), int'({cp, 1'b0}));
    end
  endtask

  // run is raised at a negedge, so sample n follows the n-th edge seen with run high
  task automatic run_xfer(input int d, input int b, input bit cp, input int halves,
                          input string req, input bit mutate, input bit already_running);
    int h = half_len(d, b);
    if (!already_running) begin
      @(negedge clk); run = 1'b1;
    end
    for (int n = 1; n <= halves * h; n++) begin
      int e;
      @(posedge clk); #1;
      e = exp_bits(n, h, cp);
      chk({sclk, lead, trail} == e[2:0], req, int'({sclk, lead, trail}), e);
      if (mutate && n == h / 2) begin
        div = ~div; brg = 6'd0; cpol = ~cpol; // R6: must be ignored
      end
    end
    @(negedge clk); run = 1'b0;
    @(posedge clk); #1;
    chk(sclk == cp && !lead && !trail, "R5", int'({sclk, lead, trail}), int'({cp, 2'b00}));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    chk({sclk, lead, trail, rdy} == 4'b0, "R5", int'({sclk, lead, trail, rdy}), 0);
    @(negedge clk); rst_n = 1'b1;

    // R4 fastest: period 20
    configure(0, 4, 1'b0, 1'b0);
    run_xfer(0, 4, 1'b0, 4, "R4", 1'b0, 1'b0);
    // R4 slowest: period 2048
    configure(3, 63, 1'b1, 1'b0);
    run_xfer(3, 63, 1'b1, 2, "R4", 1'b0, 1'b0);
    // R3 clamp of rate 0 and 3
    configure(1, 0, 1'b0, 1'b0);
    run_xfer(1, 0, 1'b0, 3, "R3", 1'b0, 1'b0);
    configure(2, 3, 1'b1, 1'b0);
    run_xfer(2, 3, 1'b1, 3, "R3", 1'b0, 1'b0);
    // R6 field writes while enabled
    configure(1, 7, 1'b0, 1'b0);
    run_xfer(1, 7, 1'b0, 4, "R6", 1'b1, 1'b0);
    // R7 run held before ready: counting starts after ready
    configure(0, 5, 1'b1, 1'b1);
    run_xfer(0, 5, 1'b1, 2, "R7", 1'b0, 1'b1);

    // R9 stop lands on the edge of the first change
    configure(0, 4, 1'b0, 1'b0);
    @(negedge clk); run = 1'b1;
    repeat (half_len(0, 4) - 1) @(posedge clk);
    @(negedge clk); run = 1'b0;
    @(posedge clk); #1;
    chk(sclk == 1'b0 && !lead && !trail, "R9", int'({sclk, lead, trail}), 0);
    run_xfer(0, 4, 1'b0, 2, "R9", 1'b0, 1'b0);

    // R5 disable mid-run and polarity follow
    @(negedge clk); run = 1'b1;
    repeat (15) @(posedge clk);
    @(negedge clk); en = 1'b0; cpol = 1'b1;
    @(posedge clk); #1;
    chk(sclk == 1'b1 && !lead && !trail && !rdy, "R5", int'({sclk, lead, trail, rdy}), 8);
    @(negedge clk); cpol = 1'b0;
    @(posedge clk); #1;
    chk(sclk == 1'b0, "R5", int'(sclk), 0);
    @(negedge clk); run = 1'b0;

    // R1 / R2 / R8 random vectors
    for (int v = 0; v < 14; v++) begin
      int d = int'($urandom_range(0, 3));
      int b = int'($urandom_range(0, 63));
      bit cp = 1'($urandom_range(0, 1));
      int hv = (d == 3 && b > 31) ? 2 : 3;
      configure(d, b, cp, 1'b0);
      run_xfer(d, b, cp, hv, (v % 2 == 0) ? "R1" : "R2", 1'b0, 1'b0);
      chk(1'b1, "R8", 0, 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule